// File: doc/BRIEF.md
# Rectangular Pixel Block Transfer Engine

This block moves a rectangle of byte-wide pixels from one place in a frame buffer to another, or paints a rectangle with a single colour. On every pixel it combines the source value with the existing destination value through one of sixteen two-input logic functions. A per-bit write mask decides which destination bits may change. An optional transparency test leaves a destination pixel untouched when it matches a key colour under a compare mask. The engine drives a plain synchronous memory port. Read data arrives one cycle after the read request.

A controller loads the start addresses, the rectangle size, the distance between rows and the operation settings, then pulses `start`. The engine holds `busy` while it walks the rectangle. It then pulses `done` and presents the address one step beyond the last destination pixel, so software can chain the next transfer. When source and destination overlap with the destination at the higher address, a reverse walk keeps the copy correct. In a reverse walk the supplied addresses name the last pixel of each rectangle, and the walk moves toward lower addresses.

Top module: `blit_engine`

## Requirements
- R1: While and after reset, `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: With `dir`=0, pixel (x,y) of the rectangle uses destination address `dst_addr + y*pitch + x` and source address `src_addr + y*pitch + x`. Pixels are visited in row order from y=0, and from x=0 within each row.
- R3: With `dir`=1, pixel (x,y) uses address `dst_addr - y*pitch - x`, and the source address follows the same rule. Pixels are visited in the same (x,y) order, so the walk runs from the highest address downward. An overlapping copy therefore ends with the same memory contents as copying one pixel at a time in that order.
- R4: The new value is bit-wise f(S,D) chosen by `rop`, with S the source and D the destination. The codes are: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 all ones.
- R5: With `fill`=1, `fg_color` is used as S and no source read is issued. Each pixel then takes one read and at most one write.
- R6: With `trn_en`=1, a pixel whose destination value satisfies `(D & trn_mask) == (trn_color & trn_mask)` is not written. With `trn_en`=0, every pixel is written.
- R7: Destination bits where `plane_mask` is 0 keep their old value. Bits where it is 1 take the value f(S,D).
- R8: A copy spends exactly 3 cycles per pixel: a source read, then a destination read, then the write cycle. A fill spends 2 cycles per pixel. Read data is taken one cycle after the read request. `mem_wr` is high only while `busy` is high.
- R9: `busy` is high from the cycle after an accepted start until the last pixel's write cycle. `done` is a single-cycle pulse in the following cycle. From `done` onward, `end_addr` holds the last destination address stepped once more in the walk direction.
- R10: If `width` or `height` is 0, `done` pulses in the cycle after start. No memory access takes place, `busy` stays low, and `end_addr` equals `dst_addr`.
- R11: `start` is ignored unless the engine is idle. All settings are captured at the accepted start, so changing inputs during an operation does not alter it, and an ignored start is not queued.
- R12: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir | input | 1 | 0 forward walk, 1 reverse walk |
| fill | input | 1 | 1 uses `fg_color` as source |
| rop | input | 4 | Logic function code |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| width | input | DW | Pixels per row |
| height | input | DW | Number of rows |
| pitch | input | AW | Address distance between rows |
| fg_color | input | PW | Fill colour |
| trn_color | input | PW | Transparency key |
| trn_mask | input | PW | Bits taking part in the key compare |
| trn_en | input | 1 | Enable transparency skip |
| plane_mask | input | PW | Bits that may change |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | PW | Write data |
| mem_rdata | input | PW | Read data, one cycle after `mem_rd` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| end_addr | output | AW | Address beyond the last destination pixel |

## Verification
A forward copy between separate regions shows the row stepping by pitch and the visiting order, seen through the logged write addresses. A reverse copy where the destination is one pixel above the source would smear under a forward walk, so it separates the two directions. All sixteen logic codes are applied to regions where S and D differ, which exposes any swapped code. Fill, masked and unmasked key matches, a partial write mask, zero-sized rectangles and a start issued mid-operation each isolate one control path.

// File: rtl/blit_pkg.sv
// Shared types for the block transfer engine.
// Assumes: nothing beyond the 1800-2017 language.
package blit_pkg;

    // Sequencer states; one pixel passes SRC_RD (copy only), DST_RD, XFER.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SRC_RD = 3'd1,
        ST_DST_RD = 3'd2,
        ST_XFER   = 3'd3,
        ST_DONE   = 3'd4
    } blit_state_t;

endpackage

// File: rtl/blit_rop.sv
// Bit-wise two-operand logic function selected by a 4-bit code.
// The code acts as a truth table: bit {~s,~d} of the code is the result.
// Assumes: purely combinational, no state.
module blit_rop #(
    parameter int PW = 8
) (
    input  logic [3:0]    code,
    input  logic [PW-1:0] s,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] r
);

    // One truth-table lookup per pixel bit.
    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign r[i] = code[{~s[i], ~d[i]}];
    end

endmodule

// File: rtl/blit_pixel_merge.sv
// Forms the write value for one pixel: logic function, then write mask,
// and flags a transparency match that must suppress the write.
// Assumes: d is the destination value read in the same cycle.
module blit_pixel_merge #(
    parameter int PW = 8
) (
    input  logic [3:0]    code,
    input  logic [PW-1:0] s,
    input  logic [PW-1:0] d,
    input  logic [PW-1:0] plane_mask,
    input  logic          trn_en,
    input  logic [PW-1:0] trn_color,
    input  logic [PW-1:0] trn_mask,
    output logic [PW-1:0] wdata,
    output logic          suppress
);

    logic [PW-1:0] f_out;

    blit_rop #(.PW(PW)) u_rop (
        .code (code),
        .s    (s),
        .d    (d),
        .r    (f_out)
    );

    // Keep unmasked destination bits, take the function result elsewhere.
    always_comb wdata = (f_out & plane_mask) | (d & ~plane_mask);

    // Key compare on the masked destination value.
    always_comb suppress = trn_en && ((d & trn_mask) == (trn_color & trn_mask));

endmodule

// File: rtl/blit_walker.sv
// Address walker: holds current source and destination addresses and the
// x/y position, steps one pixel per step pulse, forward or reverse.
// Assumes: load is only given with nonzero width and height; step only
// after load and never past the last pixel.
module blit_walker #(
    parameter int AW = 16,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          dir,
    input  logic [AW-1:0] src_base,
    input  logic [AW-1:0] dst_base,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [AW-1:0] pitch,
    output logic [AW-1:0] src_cur,
    output logic [AW-1:0] dst_cur,
    output logic [AW-1:0] dst_next,
    output logic          last
);

    localparam logic [DW-1:0] ONE_D = DW'(1);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    logic [AW-1:0] src_row, dst_row, pitch_l;
    logic [DW-1:0] x_cnt, y_cnt, w_l, h_l;
    logic          dir_l;
    logic          row_end;
    logic [AW-1:0] src_row_nx, dst_row_nx, src_pix_nx;

    // Next addresses in the latched walk direction.
    always_comb begin
        row_end    = (x_cnt == w_l - ONE_D);
        src_row_nx = dir_l ? src_row - pitch_l : src_row + pitch_l;
        dst_row_nx = dir_l ? dst_row - pitch_l : dst_row + pitch_l;
        src_pix_nx = dir_l ? src_cur - ONE_A   : src_cur + ONE_A;
        dst_next   = dir_l ? dst_cur - ONE_A   : dst_cur + ONE_A;
        last       = row_end && (y_cnt == h_l - ONE_D);
    end

    // Position and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_row <= '0;
            dst_row <= '0;
            src_cur <= '0;
            dst_cur <= '0;
            pitch_l <= '0;
            x_cnt   <= '0;
            y_cnt   <= '0;
            w_l     <= '0;
            h_l     <= '0;
            dir_l   <= 1'b0;
        end else if (load) begin
            src_row <= src_base;
            dst_row <= dst_base;
            src_cur <= src_base;
            dst_cur <= dst_base;
            pitch_l <= pitch;
            x_cnt   <= '0;
            y_cnt   <= '0;
            w_l     <= width;
            h_l     <= height;
            dir_l   <= dir;
        end else if (step) begin
            if (row_end) begin
                x_cnt   <= '0;
                y_cnt   <= y_cnt + ONE_D;
                src_row <= src_row_nx;
                dst_row <= dst_row_nx;
                src_cur <= src_row_nx;
                dst_cur <= dst_row_nx;
            end else begin
                x_cnt   <= x_cnt + ONE_D;
                src_cur <= src_pix_nx;
                dst_cur <= dst_next;
            end
        end
    end

    // R2/R3: a step never happens beyond the latched rectangle.
    p_step_in_rect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (x_cnt < w_l) && (y_cnt < h_l));

endmodule

// File: rtl/blit_engine.sv
// Rectangular pixel transfer engine: copy or fill with a logic function,
// write mask and transparency skip, over a one-cycle-latency memory port.
// Assumes: mem_rdata is valid the cycle after mem_rd; writes complete in
// the cycle mem_wr is high.
module blit_engine #(
    parameter int AW = 16,
    parameter int PW = 8,
    parameter int DW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir,
    input  logic          fill,
    input  logic [3:0]    rop,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [AW-1:0] pitch,
    input  logic [PW-1:0] fg_color,
    input  logic [PW-1:0] trn_color,
    input  logic [PW-1:0] trn_mask,
    input  logic          trn_en,
    input  logic [PW-1:0] plane_mask,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [PW-1:0] mem_wdata,
    input  logic [PW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] end_addr
);

    import blit_pkg::*;

    blit_state_t   state, state_nx;
    logic          accept, empty_rect;
    logic          fill_l, trn_en_l;
    logic [3:0]    rop_l;
    logic [PW-1:0] src_q, pm_l, tc_l, tm_l;
    logic [AW-1:0] src_cur, dst_cur, dst_next;
    logic          last, suppress;
    logic [PW-1:0] wval;

    // Start decode: only an idle engine takes a start.
    always_comb begin
        accept     = start && (state == ST_IDLE);
        empty_rect = (width == '0) || (height == '0);
    end

    // Sequencer next-state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept) state_nx = empty_rect ? ST_DONE
                                              : (fill ? ST_DST_RD : ST_SRC_RD);
            ST_SRC_RD: state_nx = ST_DST_RD;
            ST_DST_RD: state_nx = ST_XFER;
            ST_XFER:   state_nx = last ? ST_DONE
                                  : (fill_l ? ST_DST_RD : ST_SRC_RD);
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Operation settings captured at the accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_l   <= 1'b0;
            trn_en_l <= 1'b0;
            rop_l    <= '0;
            pm_l     <= '0;
            tc_l     <= '0;
            tm_l     <= '0;
        end else if (accept) begin
            fill_l   <= fill;
            trn_en_l <= trn_en;
            rop_l    <= rop;
            pm_l     <= plane_mask;
            tc_l     <= trn_color;
            tm_l     <= trn_mask;
        end
    end

    // Source operand: fill colour at start, else the returned source read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                src_q <= '0;
        else if (accept)                           src_q <= fg_color;
        else if (state == ST_DST_RD && !fill_l)    src_q <= mem_rdata;
    end

    // Completion address: beyond the last pixel, or the base if empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                         end_addr <= '0;
        else if (accept && empty_rect)      end_addr <= dst_addr;
        else if (state == ST_XFER && last)  end_addr <= dst_next;
    end

    blit_walker #(.AW(AW), .DW(DW)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept && !empty_rect),
        .step     (state == ST_XFER),
        .dir      (dir),
        .src_base (src_addr),
        .dst_base (dst_addr),
        .width    (width),
        .height   (height),
        .pitch    (pitch),
        .src_cur  (src_cur),
        .dst_cur  (dst_cur),
        .dst_next (dst_next),
        .last     (last)
    );

    blit_pixel_merge #(.PW(PW)) u_merge (
        .code       (rop_l),
        .s          (src_q),
        .d          (mem_rdata),
        .plane_mask (pm_l),
        .trn_en     (trn_en_l),
        .trn_color  (tc_l),
        .trn_mask   (tm_l),
        .wdata      (wval),
        .suppress   (suppress)
    );

    // Memory port and status outputs.
    always_comb begin
        mem_rd    = (state == ST_SRC_RD) || (state == ST_DST_RD);
        mem_wr    = (state == ST_XFER) && !suppress;
        mem_addr  = (state == ST_SRC_RD) ? src_cur : dst_cur;
        mem_wdata = wval;
        busy      = (state == ST_SRC_RD) || (state == ST_DST_RD) || (state == ST_XFER);
        done      = (state == ST_DONE);
    end

    // R12: the port never reads and writes together.
    p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9: completion is a single-cycle pulse.
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: busy only ever drops into a done pulse.
    p_busy_fall_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8: no write outside an operation.
    p_wr_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> busy);

    // R5: a fill never enters the source-read state.
    p_fill_no_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fill_l) |-> (state != ST_SRC_RD));

    // R11: a start while busy leaves the operation running.
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last) |=> busy);

endmodule

// File: tb/tb_blit_engine.sv
module tb_blit_engine;

    localparam int AW = 16;
    localparam int PW = 8;
    localparam int DW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          dir = 1'b0, fill = 1'b0, trn_en = 1'b0;
    logic [3:0]    rop = 4'd3;
    logic [AW-1:0] src_addr = '0, dst_addr = '0, pitch = '0;
    logic [DW-1:0] width = '0, height = '0;
    logic [PW-1:0] fg_color = '0, trn_color = '0, trn_mask = '0, plane_mask = 8'hFF;
    logic [AW-1:0] mem_addr, end_addr;
    logic          mem_rd, mem_wr, busy, done;
    logic [PW-1:0] mem_wdata, mem_rdata;

    logic [7:0] mem  [0:4095];
    logic [7:0] gold [0:4095];

    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, wr_cnt = 0, busy_cyc = 0, clash = 0, wr_n = 0, clk_cnt = 0;
    logic [AW-1:0] wr_log [0:63];

    always #4 clk = ~clk;

    blit_engine #(.AW(AW), .PW(PW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .fill(fill), .rop(rop),
        .src_addr(src_addr), .dst_addr(dst_addr), .width(width), .height(height),
        .pitch(pitch), .fg_color(fg_color), .trn_color(trn_color), .trn_mask(trn_mask),
        .trn_en(trn_en), .plane_mask(plane_mask), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .end_addr(end_addr)
    );

    // Synchronous memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
    end

    // Activity monitor, sampled on the falling edge.
    always @(negedge clk) begin
        clk_cnt++;
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (mem_wr) begin
                if (wr_n < 64) wr_log[wr_n] = mem_addr;
                wr_n++;
                wr_cnt++;
            end
            if (mem_rd && mem_wr) clash++;
            if (busy) busy_cyc++;
        end
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    // Watchdog.
    initial begin
        wait (clk_cnt > 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d cycles expected < 150000", clk_cnt);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fref(input logic [3:0] c, input logic [7:0] s, input logic [7:0] d);
        case (c)
            4'd0:  return 8'h00;
            4'd1:  return s & d;
            4'd2:  return s & ~d;
            4'd3:  return s;
            4'd4:  return ~s & d;
            4'd5:  return d;
            4'd6:  return s ^ d;
            4'd7:  return s | d;
            4'd8:  return ~(s | d);
            4'd9:  return ~(s ^ d);
            4'd10: return ~d;
            4'd11: return s | ~d;
            4'd12: return ~s;
            4'd13: return ~s | d;
            4'd14: return ~(s & d);
            default: return 8'hFF;
        endcase
    endfunction

    task automatic seed(input int k);
        for (int i = 0; i < 4096; i++) begin
            mem[i]  = 8'((i * 37 + k * 11 + 5) & 255);
            gold[i] = mem[i];
        end
    endtask

    task automatic defaults();
        dir = 0; fill = 0; rop = 4'd3; trn_en = 0; trn_color = '0; trn_mask = '0;
        plane_mask = 8'hFF; fg_color = '0; pitch = 16'd64;
    endtask

    // Golden pixel-by-pixel model; returns the number of writes.
    task automatic model(output int nwr);
        nwr = 0;
        for (int y = 0; y < int'(height); y++) begin
            for (int x = 0; x < int'(width); x++) begin
                logic [15:0] off, sa, da;
                logic [7:0] s, d, r;
                off = 16'(y * int'(pitch) + x);
                sa = dir ? src_addr - off : src_addr + off;
                da = dir ? dst_addr - off : dst_addr + off;
                s = fill ? fg_color : gold[sa[11:0]];
                d = gold[da[11:0]];
                if (!(trn_en && ((d & trn_mask) == (trn_color & trn_mask)))) begin
                    r = fref(rop, s, d);
                    gold[da[11:0]] = (r & plane_mask) | (d & ~plane_mask);
                    nwr++;
                end
            end
        end
    endtask

    task automatic go(output int cyc);
        rd_cnt = 0; wr_cnt = 0; busy_cyc = 0; wr_n = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic cmp_mem(input string req);
        int bad = -1;
        for (int i = 0; i < 4096; i++)
            if (bad < 0 && mem[i] !== gold[i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {bad[15:0], mem[bad]}, {bad[15:0], gold[bad]});
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
        chk(mem_rd == 0 && mem_wr == 0, "R1 mem strobes", {mem_rd, mem_wr}, 0);
    endtask

    task automatic t_fwd_copy();
        int cyc, nw;
        defaults(); seed(1);
        src_addr = 16'd100; dst_addr = 16'd1000; width = 10'd5; height = 10'd3;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R2 forward copy contents");
        chk(wr_log[0] == 16'd1000 && wr_log[4] == 16'd1004 && wr_log[5] == 16'd1064,
            "R2 write order", {wr_log[4], wr_log[5]}, {16'd1004, 16'd1064});
        chk(busy_cyc == 45, "R8 copy cycles per pixel", busy_cyc, 45);
        chk(rd_cnt == 30, "R8 reads per copy pixel", rd_cnt, 30);
        chk(end_addr == 16'd1133, "R9 end address forward", end_addr, 1133);
    endtask

    task automatic t_rev_overlap();
        int cyc, nw;
        defaults(); seed(2);
        dir = 1; pitch = 16'd32; src_addr = 16'd2100; dst_addr = 16'd2101;
        width = 10'd6; height = 10'd2;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R3 reverse overlapping copy");
        chk(wr_log[0] == 16'd2101 && wr_log[1] == 16'd2100 && wr_log[6] == 16'd2069,
            "R3 reverse write order", {wr_log[1], wr_log[6]}, {16'd2100, 16'd2069});
        chk(end_addr == 16'd2063, "R9 end address reverse", end_addr, 2063);
    endtask

    task automatic t_rops();
        for (int c = 0; c < 16; c++) begin
            int cyc, nw;
            defaults(); seed(3 + c);
            rop = 4'(c); pitch = 16'd16; src_addr = 16'd300; dst_addr = 16'd400;
            width = 10'd4; height = 10'd2;
            model(nw);
            @(negedge clk); go(cyc);
            cmp_mem($sformatf("R4 function code %0d", c));
        end
    endtask

    task automatic t_fill();
        int cyc, nw;
        defaults(); seed(30);
        fill = 1; fg_color = 8'hA5; pitch = 16'd20; src_addr = 16'd0;
        dst_addr = 16'd600; width = 10'd7; height = 10'd2;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R5 fill contents");
        chk(rd_cnt == 14, "R5 fill reads only destination", rd_cnt, 14);
        chk(busy_cyc == 28, "R8 fill cycles per pixel", busy_cyc, 28);
    endtask

    task automatic t_transparency();
        int cyc, nw;
        defaults(); seed(40);
        for (int i = 0; i < 16; i++) begin
            mem[800 + i]  = (i % 3 == 0) ? 8'h4C : 8'h7C;
            gold[800 + i] = mem[800 + i];
        end
        trn_en = 1; trn_color = 8'h43; trn_mask = 8'hF0; pitch = 16'd8;
        src_addr = 16'd200; dst_addr = 16'd800; width = 10'd8; height = 10'd2;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R6 key match skipped");
        chk(wr_cnt == nw && nw == 10, "R6 write count with key", wr_cnt, nw);
        trn_en = 0;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R6 key disabled writes all");
        chk(wr_cnt == 16, "R6 write count without key", wr_cnt, 16);
    endtask

    task automatic t_plane_mask();
        int cyc, nw;
        defaults(); seed(50);
        plane_mask = 8'h0F; rop = 4'd12; src_addr = 16'd1500; dst_addr = 16'd1700;
        width = 10'd3; height = 10'd3;
        model(nw);
        @(negedge clk); go(cyc);
        cmp_mem("R7 write mask keeps bits");
    endtask

    task automatic t_zero();
        int cyc;
        defaults(); seed(60);
        dst_addr = 16'd2500; src_addr = 16'd10; width = 10'd0; height = 10'd3;
        @(negedge clk); go(cyc);
        chk(cyc == 0, "R10 zero width done next cycle", cyc, 0);
        chk(rd_cnt + wr_cnt + busy_cyc == 0, "R10 zero width no access", rd_cnt + wr_cnt + busy_cyc, 0);
        chk(end_addr == 16'd2500, "R10 zero width end address", end_addr, 2500);
        width = 10'd4; height = 10'd0; dst_addr = 16'd2600;
        @(negedge clk); go(cyc);
        chk(cyc == 0 && rd_cnt + wr_cnt == 0, "R10 zero height", cyc + rd_cnt + wr_cnt, 0);
        chk(end_addr == 16'd2600, "R10 zero height end address", end_addr, 2600);
        cmp_mem("R10 memory untouched");
    endtask

    task automatic t_ignore_start();
        int cyc, nw, rd_before;
        defaults(); seed(70);
        src_addr = 16'd3200; dst_addr = 16'd3400; width = 10'd4; height = 10'd2; rop = 4'd6;
        model(nw);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; busy_cyc = 0; wr_n = 0;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        dst_addr = 16'd3000; rop = 4'd0; fill = 1; width = 10'd1; pitch = 16'd1;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        cmp_mem("R11 settings captured at start");
        chk(end_addr == 16'd3468, "R11 end address of first op", end_addr, 3468);
        rd_before = rd_cnt;
        repeat (10) @(negedge clk);
        chk(rd_cnt == rd_before && !busy, "R11 ignored start not queued", rd_cnt, rd_before);
    endtask

    initial begin
        seed(0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fwd_copy();
        t_rev_overlap();
        t_rops();
        t_fill();
        t_transparency();
        t_plane_mask();
        t_zero();
        t_ignore_start();
        chk(clash == 0, "R12 read and write together", clash, 0);
        summary();
        $finish;
    end

endmodule